// File: doc/BRIEF.md
# Time-Register Update Coordinator

This block sits between a parallel register bus and a set of free-running time-of-day counters. It divides a 32.768 kHz clock enable down to one tick per second and sends that tick to the counters. It also tells software when it is safe to read the time. A status flag goes high a fixed number of slow-clock periods before every tick. An update-ended flag, which can raise an interrupt, goes high once the counters have settled after the tick.

Software reads the time fields from a user copy, not from the counters themselves. While the freeze bit in the control register is set, the user copy does not change, even though the counters keep counting. Writes to time fields are accepted only while the block is frozen. Those writes land in the user copy and are remembered per field. When software clears the freeze bit, the remembered fields are handed to the counters as a one-cycle load. All other fields of the user copy are refreshed from the live counter values.

Top module: `rtc_update_sync`

## Requirements
- R1: While reset is applied, and after it is released, every register reads 0 and `uip`, `irq`, `ld_valid` and `sec_tick` are low. Reset stays effective for two clocks after `rst_n` rises, because it is released synchronously. Register addresses are as follows: time fields at 0 to NFIELD-1, status at NFIELD, control at NFIELD+1, flag at NFIELD+2.
- R2: `sec_tick` is high in exactly the cycles in which `tick_en` is high for the DIV-th, 2·DIV-th, and so on, enable since reset.
- R3: `uip` rises on the enable that leaves LEAD further enables before the tick (the (DIV-LEAD)-th enable of each second). It stays high through the tick. Status register bit 7 reads as `uip`.
- R4: `uip` falls on the first enable after the tick. This enable is the update-done point.
- R5: While not frozen, the user copy takes every field from `live_time` at the update-done point.
- R6: While control bit 7 (freeze) is 1, the user copy holds its value across updates, and ticks continue to be issued.
- R7: A write to a time field while frozen changes that field of the user copy, which reads back at once. A write to a time field while not frozen is ignored.
- R8: In the cycle after freeze is cleared, `ld_valid` is high for one cycle. During that cycle `ld_mask` bit k is set for each field k written while frozen, and `ld_time` carries those values. At the same edge, every unwritten field of the user copy is reloaded from `live_time`.
- R9: If no field was written while frozen, clearing freeze produces no `ld_valid`, and all fields are still reloaded from `live_time`.
- R10: Flag register bit 4 (update ended) is set at every update-done point, whether frozen or not. A bus read of the flag register returns the bit and then clears it. A set arriving in the same cycle as the read takes priority.
- R11: `irq` is high exactly while flag bit 4 and control bit 4 (update interrupt enable) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle enable at the 32.768 kHz rate |
| bus_addr | input | AW | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (the flag register clears on a read) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, 0 when `bus_rd` is low |
| live_time | input | NFIELD·8 | Current counter values, field k at bits 8k+7:8k |
| sec_tick | output | 1 | One-second advance strobe to the counters |
| uip | output | 1 | Update-in-progress warning |
| irq | output | 1 | Update-ended interrupt request |
| ld_valid | output | 1 | Load strobe to the counters |
| ld_mask | output | NFIELD | Fields to load |
| ld_time | output | NFIELD·8 | Values to load |

## Verification
The bench builds the block with DIV=64, LEAD=8 and NFIELD=6, and pulses `tick_en` every fourth clock. With these values a simulated second lasts 256 clocks. Several update cycles therefore fit in a short run. The warning window, the tick and the update-done point occur many times, so every cycle can be compared against a model of the enable count. With this short second, the bench can freeze across one or two updates, and it can write fields and thaw without an update falling in the middle. Each field can then be traced from the user copy, through the load strobe, into the counters.

// File: rtl/rus_pkg.sv
package rus_pkg;
  localparam int unsigned FLD_W = 8;
  // control register bits
  localparam int unsigned FRZ_BIT  = 7;
  localparam int unsigned UEIE_BIT = 4;
  // status / flag register bits
  localparam int unsigned UIP_BIT  = 7;
  localparam int unsigned UEF_BIT  = 4;

  typedef enum logic [2:0] {
    RK_FIELD,
    RK_STAT,
    RK_CTRL,
    RK_FLAG,
    RK_NONE
  } reg_kind_e;
endpackage

// File: rtl/rus_prescale.sv
module rus_prescale #(
  parameter int DIV  = 32768,
  parameter int LEAD = 8,
  localparam int CW  = $clog2(DIV)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  output logic sec_tick,
  output logic upd_done,
  output logic uip
);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] WARN = CW'(DIV - 1 - LEAD);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          uip_q, uip_d;
  logic          pend_q, pend_d;

  always_comb begin
    cnt_d  = cnt_q;
    uip_d  = uip_q;
    pend_d = pend_q;
    if (tick_en) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
      if (pend_q) begin
        uip_d  = 1'b0;
        pend_d = 1'b0;
      end
      if (cnt_q == WARN) uip_d = 1'b1;
      if (cnt_q == LAST) pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      uip_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      uip_q  <= uip_d;
      pend_q <= pend_d;
    end
  end

  assign sec_tick = tick_en & (cnt_q == LAST);
  assign upd_done = tick_en & pend_q;
  assign uip      = uip_q;

  // R3: the warning is already up when the tick is issued
  a_r3_uip_at_tick: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> uip_q);
  // R3: the warning rises only on a slow-clock enable that is not the tick
  a_r3_uip_rise_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uip_q) |-> ($past(tick_en) && !$past(sec_tick)));
  // R4: the warning drops only at the update-done point
  a_r4_uip_fall_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uip_q) |-> $past(upd_done));
endmodule

// File: rtl/rus_shadow.sv
module rus_shadow import rus_pkg::*; #(
  parameter int NFIELD = 6,
  localparam int IW    = (NFIELD > 1) ? $clog2(NFIELD) : 1,
  localparam int TW    = NFIELD * FLD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frz,
  input  logic              fld_we,
  input  logic [IW-1:0]     fld_idx,
  input  logic [FLD_W-1:0]  wdata,
  input  logic [TW-1:0]     live_time,
  input  logic              upd_done,
  output logic [TW-1:0]     user_time,
  output logic              ld_valid,
  output logic [NFIELD-1:0] ld_mask
);
  logic frz_d1_q;
  logic thaw;
  logic [NFIELD-1:0] mask_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frz_d1_q <= 1'b0;
    else        frz_d1_q <= frz;
  end

  assign thaw = frz_d1_q & ~frz;

  for (genvar g = 0; g < NFIELD; g++) begin : g_fld
    localparam logic [IW-1:0] IDX = IW'(g);
    logic [FLD_W-1:0] u_q, u_d;
    logic             m_q, m_d;
    logic             hit;

    assign hit = frz & fld_we & (fld_idx == IDX);

    always_comb begin
      u_d = u_q;
      m_d = m_q;
      if (hit) begin
        u_d = wdata;
        m_d = 1'b1;
      end else if (thaw) begin
        if (!m_q) u_d = live_time[g*FLD_W +: FLD_W];
        m_d = 1'b0;
      end else if (upd_done && !frz) begin
        u_d = live_time[g*FLD_W +: FLD_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        u_q <= '0;
        m_q <= 1'b0;
      end else begin
        u_q <= u_d;
        m_q <= m_d;
      end
    end

    assign user_time[g*FLD_W +: FLD_W] = u_q;
    assign mask_vec[g] = m_q;
  end

  assign ld_valid = thaw & (|mask_vec);
  assign ld_mask  = mask_vec;

  // R6: a frozen copy with no field write does not change at the next edge
  a_r6_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (frz && !fld_we) |=> $stable(user_time));
  // R7: outside freeze, thaw and update, field writes leave the copy alone
  a_r7_unfrozen_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!frz && !thaw && !upd_done) |=> $stable(user_time));
  // R8: a load only follows a clearing of the freeze bit
  a_r8_load_after_thaw: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> ($past(frz) && !frz));
  // R8: the written-field record is emptied by the load
  a_r8_mask_emptied: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> (mask_vec == '0));
endmodule

// File: rtl/rus_irq.sv
module rus_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_done,
  input  logic flag_rd,
  input  logic ie,
  output logic uef,
  output logic irq
);
  logic uef_q, uef_d;

  always_comb begin
    uef_d = uef_q;
    if (upd_done)     uef_d = 1'b1;
    else if (flag_rd) uef_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uef_q <= 1'b0;
    else        uef_q <= uef_d;
  end

  assign uef = uef_q;
  assign irq = uef_q & ie;

  // R10: each update-done point leaves the flag set
  a_r10_set_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |=> uef_q);
  // R10: a read without a coincident update clears the flag
  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !upd_done) |=> !uef_q);
  // R10: the flag only appears because of an update
  a_r10_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uef_q) |-> $past(upd_done));
endmodule

// File: rtl/rtc_update_sync.sv
module rtc_update_sync import rus_pkg::*; #(
  parameter int DIV    = 32768,
  parameter int LEAD   = 8,
  parameter int NFIELD = 6,
  localparam int AW    = $clog2(NFIELD + 3),
  localparam int TW    = NFIELD * FLD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [TW-1:0]     live_time,
  output logic              sec_tick,
  output logic              uip,
  output logic              irq,
  output logic              ld_valid,
  output logic [NFIELD-1:0] ld_mask,
  output logic [TW-1:0]     ld_time
);
  localparam int IW = (NFIELD > 1) ? $clog2(NFIELD) : 1;
  localparam logic [AW-1:0] A_STAT = AW'(NFIELD);
  localparam logic [AW-1:0] A_CTRL = AW'(NFIELD + 1);
  localparam logic [AW-1:0] A_FLAG = AW'(NFIELD + 2);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  // address decode
  reg_kind_e     kind;
  logic [IW-1:0] fld_idx;
  always_comb begin
    if (bus_addr < A_STAT)       kind = RK_FIELD;
    else if (bus_addr == A_STAT) kind = RK_STAT;
    else if (bus_addr == A_CTRL) kind = RK_CTRL;
    else if (bus_addr == A_FLAG) kind = RK_FLAG;
    else                         kind = RK_NONE;
  end
  assign fld_idx = bus_addr[IW-1:0];

  // control register
  logic frz_q, frz_d, ueie_q, ueie_d;
  always_comb begin
    frz_d  = frz_q;
    ueie_d = ueie_q;
    if (bus_wr && kind == RK_CTRL) begin
      frz_d  = bus_wdata[FRZ_BIT];
      ueie_d = bus_wdata[UEIE_BIT];
    end
  end
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      frz_q  <= 1'b0;
      ueie_q <= 1'b0;
    end else begin
      frz_q  <= frz_d;
      ueie_q <= ueie_d;
    end
  end

  logic upd_done, uef, fld_we, flag_rd;
  logic [TW-1:0] user_time;

  assign fld_we  = bus_wr & (kind == RK_FIELD);
  assign flag_rd = bus_rd & (kind == RK_FLAG);

  rus_prescale #(.DIV(DIV), .LEAD(LEAD)) u_presc (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .tick_en  (tick_en),
    .sec_tick (sec_tick),
    .upd_done (upd_done),
    .uip      (uip)
  );

  rus_shadow #(.NFIELD(NFIELD)) u_shadow (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .frz       (frz_q),
    .fld_we    (fld_we),
    .fld_idx   (fld_idx),
    .wdata     (bus_wdata),
    .live_time (live_time),
    .upd_done  (upd_done),
    .user_time (user_time),
    .ld_valid  (ld_valid),
    .ld_mask   (ld_mask)
  );

  rus_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .upd_done (upd_done),
    .flag_rd  (flag_rd),
    .ie       (ueie_q),
    .uef      (uef),
    .irq      (irq)
  );

  assign ld_time = user_time;

  // read mux
  logic [FLD_W-1:0] ufield [NFIELD];
  for (genvar g = 0; g < NFIELD; g++) begin : g_rd
    assign ufield[g] = user_time[g*FLD_W +: FLD_W];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (kind)
        RK_FIELD: bus_rdata = ufield[fld_idx];
        RK_STAT:  bus_rdata[UIP_BIT] = uip;
        RK_CTRL: begin
          bus_rdata[FRZ_BIT]  = frz_q;
          bus_rdata[UEIE_BIT] = ueie_q;
        end
        RK_FLAG:  bus_rdata[UEF_BIT] = uef;
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R11: the request never stands without its enable
  a_r11_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq |-> ueie_q);
  // R2: a tick is only issued on a slow-clock enable
  a_r2_tick_on_enable: assert property (@(posedge clk) disable iff (!rst_s_n)
    sec_tick |-> tick_en);
endmodule

// File: tb/rtc_update_sync_tb_top.sv
module rtc_update_sync_tb_top;
  localparam int DIV = 64;
  localparam int LEAD = 8;
  localparam int NF = 6;
  localparam int AW = $clog2(NF + 3);
  localparam int TW = NF * 8;
  localparam logic [AW-1:0] A_STAT = AW'(NF);
  localparam logic [AW-1:0] A_CTRL = AW'(NF + 1);
  localparam logic [AW-1:0] A_FLAG = AW'(NF + 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [TW-1:0] live_time;
  logic sec_tick, uip, irq, ld_valid;
  logic [NF-1:0] ld_mask;
  logic [TW-1:0] ld_time;

  always #2 clk = ~clk;

  rtc_update_sync #(.DIV(DIV), .LEAD(LEAD), .NFIELD(NF)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .live_time(live_time), .sec_tick(sec_tick), .uip(uip), .irq(irq),
    .ld_valid(ld_valid), .ld_mask(ld_mask), .ld_time(ld_time)
  );

  int nchk = 0, nerr = 0;
  logic [7:0] live [NF];
  for (genvar g = 0; g < NF; g++) begin : g_live
    assign live_time[g*8 +: 8] = live[g];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // reference model of the enable count and counters
  bit run = 0;
  int ph = 0, m_cnt = 0, done_cnt = 0;
  bit m_uip = 0, m_pend = 0;
  bit exp_ld = 0, ld_seen = 0;
  logic [NF-1:0] exp_mask = '0;
  logic [7:0] exp_val [NF];

  always @(negedge clk) begin
    if (!run) begin
      for (int k = 0; k < NF; k++) live[k] = 8'h10 + 8'(k);
      live[0] = 8'h00;
    end else begin
      if (tick_en) begin
        if (m_pend) begin m_uip = 0; m_pend = 0; done_cnt++; end
        if (m_cnt == DIV - 1 - LEAD) m_uip = 1;
        if (m_cnt == DIV - 1) begin m_pend = 1; m_cnt = 0; live[0] = live[0] + 8'd1; end
        else m_cnt++;
      end
      chk(uip === m_uip, "R3 R4 uip", 32'(uip), 32'(m_uip));
      if (ld_valid) begin
        ld_seen = 1;
        chk(exp_ld, "R8 R9 unexpected ld_valid", 1, 0);
        chk(ld_mask === exp_mask, "R8 ld_mask", 32'(ld_mask), 32'(exp_mask));
        for (int k = 0; k < NF; k++)
          if (ld_mask[k]) begin
            chk(ld_time[k*8 +: 8] === exp_val[k], "R8 ld_time", 32'(ld_time[k*8 +: 8]), 32'(exp_val[k]));
            live[k] = ld_time[k*8 +: 8];
          end
        exp_ld = 0;
      end
      ph = (ph + 1) % 4;
      tick_en = (ph == 0);
      #1;
      chk(sec_tick === (tick_en && m_cnt == DIV - 1), "R2 sec_tick", 32'(sec_tick),
          32'(tick_en && m_cnt == DIV - 1));
    end
  end

  // scoreboard: driver pushes expectations, monitor pops on each read
  logic [7:0] q_val[$];
  string q_tag[$];

  always @(negedge clk) begin
    #1;
    if (bus_rd) begin
      if (q_val.size() == 0) chk(0, "scoreboard empty", 0, 0);
      else begin
        logic [7:0] v;
        string t;
        v = q_val.pop_front();
        t = q_tag.pop_front();
        chk(bus_rdata === v, t, 32'(bus_rdata), 32'(v));
      end
    end
  end

  task automatic rd_exp(input logic [AW-1:0] a, input logic [7:0] e, input string tag);
    q_val.push_back(e);
    q_tag.push_back(tag);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic wait_done(input int n);
    int target;
    target = done_cnt + n;
    while (done_cnt < target) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [7:0] frozen0;
    repeat (3) @(negedge clk);
    // R1: state under reset
    chk(uip === 0 && irq === 0 && ld_valid === 0 && sec_tick === 0, "R1 outputs in reset", 32'({uip, irq, ld_valid, sec_tick}), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    for (int k = 0; k < NF + 3; k++) rd_exp(AW'(k), 8'h00, "R1 register after reset");
    chk(uip === 0 && irq === 0 && ld_valid === 0, "R1 outputs after reset", 32'({uip, irq, ld_valid}), 0);
    run = 1;

    // R5: refresh after the first update
    wait_done(1);
    for (int k = 0; k < NF; k++) rd_exp(AW'(k), live[k], "R5 field refreshed");
    chk(irq === 0, "R11 irq without enable", 32'(irq), 0);

    // R7: write while not frozen is ignored
    wr(AW'(2), 8'h77);
    rd_exp(AW'(2), 8'h12, "R7 unfrozen write ignored");

    // R11 / R10: enable and acknowledge
    wr(A_CTRL, 8'h10);
    @(negedge clk);
    chk(irq === 1, "R11 irq with enable", 32'(irq), 1);
    rd_exp(A_FLAG, 8'h10, "R10 flag set");
    chk(irq === 0, "R11 irq after clear", 32'(irq), 0);
    rd_exp(A_FLAG, 8'h00, "R10 flag cleared by read");
    rd_exp(A_CTRL, 8'h10, "R11 control readback");

    // R3 / R4 through the status register
    while (!m_uip) @(negedge clk);
    rd_exp(A_STAT, 8'h80, "R3 status warning high");
    wait_done(1);
    rd_exp(A_STAT, 8'h00, "R4 status warning low");
    rd_exp(AW'(2), 8'h12, "R7 field unchanged after update");

    // R6: freeze across two updates
    frozen0 = live[0];
    wr(A_CTRL, 8'h90);
    wait_done(2);
    rd_exp(AW'(0), frozen0, "R6 frozen field holds");
    chk(live[0] == frozen0 + 8'd2, "R6 ticks continue", 32'(live[0]), 32'(frozen0 + 8'd2));
    rd_exp(A_FLAG, 8'h10, "R10 flag set while frozen");

    // R7 / R8: write while frozen, then thaw
    wr(AW'(1), 8'h42);
    wr(AW'(3), 8'h55);
    rd_exp(AW'(1), 8'h42, "R7 frozen write readback");
    rd_exp(AW'(3), 8'h55, "R7 frozen write readback");
    exp_mask = 6'b001010;
    exp_val[1] = 8'h42;
    exp_val[3] = 8'h55;
    exp_ld = 1;
    ld_seen = 0;
    wr(A_CTRL, 8'h10);
    @(negedge clk);
    chk(ld_seen == 1, "R8 load issued", 32'(ld_seen), 1);
    rd_exp(AW'(0), live[0], "R8 unwritten field reloaded");
    rd_exp(AW'(1), 8'h42, "R8 written field kept");
    rd_exp(AW'(3), 8'h55, "R8 written field kept");
    wait_done(1);
    rd_exp(AW'(1), 8'h42, "R8 counters took load");

    // R9: freeze and thaw without writes
    frozen0 = live[0];
    wr(A_CTRL, 8'h90);
    wait_done(1);
    rd_exp(AW'(0), frozen0, "R6 frozen field holds");
    ld_seen = 0;
    wr(A_CTRL, 8'h00);
    @(negedge clk);
    chk(ld_seen == 0, "R9 no load without writes", 32'(ld_seen), 0);
    rd_exp(AW'(0), live[0], "R9 field reloaded on thaw");
    rd_exp(AW'(4), live[4], "R9 field reloaded on thaw");

    repeat (4) @(negedge clk);
    chk(q_val.size() == 0, "scoreboard drained", 32'(q_val.size()), 0);
    finish_run();
  end
endmodule